// File: doc/BRIEF.md
# Switching-Period Duty Counter with Predistortion

This block measures how long a switching-node signal stays high in each switching period. It counts with a fast clock that is phase-locked at 64 times the switching rate, so one period covers 64 ticks. At every period boundary it issues two 6-bit codes that set the charge and discharge timing of a downstream triangular-wave generator. The first is the ON code, the number of ticks the node was high. The second is the OFF code, the rest of the period.

Downstream processing delays the falling edge and so adds a small duty error that grows with the duty ratio. A signed 4-bit predistortion setting is added to the measured ON count to cancel it. The result is clamped to the code range and the OFF code is derived from the adjusted value. The raw node level is brought into the clock domain by a two-flop synchronizer, and a period boundary is the rising edge of the synchronized level. A period with no rising edge for too long is a fault. The measurement then stops, a timeout flag is raised and the published codes stay as they were.

The period controller has three states:
- `ST_WAIT_EDGE` (after reset): moves to `ST_MEASURE` on the first rising edge, without publishing.
- `ST_MEASURE`: on a rising edge it publishes and restarts the count, staying in `ST_MEASURE`. When 128 ticks pass with no rising edge it moves to `ST_STALLED`.
- `ST_STALLED`: moves back to `ST_MEASURE` on the next rising edge, without publishing.

Top module: `duty_meas_predist`

## Requirements
- R1: After reset, `on_code_o` and `off_code_o` are 0, and `code_valid_o` and `timeout_o` are 0.
- R2: With a predistortion of 0, the ON code published at a boundary equals the number of clock cycles in which the synchronized node was high, counted from the previous rising edge up to but not including the current one.
- R3: The OFF code is 64 minus the published ON code. When the ON code is 0, the OFF code is 63.
- R4: `predist_i` is a two's-complement offset from -8 to +7 (bit 3 is the sign) and is added to the measured count. It is sampled in the cycle of the boundary.
- R5: The adjusted ON code saturates at 0 below and at 63 above.
- R6: Both codes change only in the cycle where `code_valid_o` is high. That strobe lasts exactly one cycle, and the codes hold their values until the next boundary.
- R7: A rising edge of `sw_node_i` that is first sampled at clock edge E makes `code_valid_o` and the new codes appear at clock edge E+2.
- R8: The first rising edge after reset, and the first after a timeout, starts a measurement but publishes nothing.
- R9: If 128 cycles pass after a rising edge with no new rising edge, `timeout_o` goes high and stays high with no valid strobe and unchanged codes. The next rising edge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast counting clock, 64 ticks per switching period |
| rst_ni | input | 1 | Active-low synchronous reset |
| sw_node_i | input | 1 | Raw switching-node level, asynchronous |
| predist_i | input | 4 | Signed ON-code offset, two's complement |
| on_code_o | output | 6 | Registered adjusted ON code |
| off_code_o | output | 6 | Registered OFF code |
| code_valid_o | output | 1 | One-cycle strobe when new codes are published |
| timeout_o | output | 1 | High while no rising edge has arrived within the limit |

## Verification
A rising input driven before clock edge E passes two synchronizer flops and the output register, so the strobe and codes are due at E+2. The directed latency test samples them on the falling edge after that clock edge and confirms the strobe is absent on the two falling edges before it. For the table of duty and offset vectors, the bench waits for the third strobe after changing a setting, because the period in progress when the setting changed is measured with mixed inputs. It then compares the codes while the strobe is high, and compares them again ten cycles later to confirm they are held. The timeout test waits well past 128 cycles of a quiet node before checking the flag and the strobe count. It then checks that the first new edge publishes nothing and the second publishes correct codes.

// File: rtl/duty_meas_pkg.sv
package duty_meas_pkg;
    typedef enum logic [1:0] {
        ST_WAIT_EDGE = 2'd0,
        ST_MEASURE   = 2'd1,
        ST_STALLED   = 2'd2
    } meas_state_t;
endpackage

// File: rtl/duty_meas_sync.sv
module duty_meas_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/duty_meas_period_fsm.sv
module duty_meas_period_fsm
    import duty_meas_pkg::*;
#(
    parameter int CODE_W        = 6,
    parameter int TIMEOUT_TICKS = 128
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              level_i,
    input  logic              rise_i,
    output logic              boundary_o,
    output logic [CODE_W-1:0] high_cnt_o,
    output logic              stalled_o
);
    localparam int TICK_W = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};
    localparam logic [TICK_W-1:0] TICK_LIM = TICK_W'(TIMEOUT_TICKS);

    meas_state_t       state_q, state_d;
    logic [TICK_W-1:0] tick_q;
    logic [CODE_W-1:0] high_q;

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_WAIT_EDGE;
        else         state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        boundary_o = 1'b0;
        stalled_o  = 1'b0;
        unique case (state_q)
            ST_WAIT_EDGE: begin
                if (rise_i) state_d = ST_MEASURE;
            end
            ST_MEASURE: begin
                if (rise_i) begin
                    boundary_o = 1'b1;
                end else if (tick_q == TICK_LIM) begin
                    state_d = ST_STALLED;
                end
            end
            ST_STALLED: begin
                stalled_o = 1'b1;
                if (rise_i) state_d = ST_MEASURE;
            end
            default: state_d = ST_WAIT_EDGE;
        endcase
    end

    // tick and high-level counters
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            tick_q <= '0;
            high_q <= '0;
        end else if (rise_i) begin
            tick_q <= TICK_W'(1);
            high_q <= CODE_W'(1);
        end else if (state_q == ST_MEASURE && tick_q != TICK_LIM) begin
            tick_q <= tick_q + TICK_W'(1);
            if (level_i && high_q != MAX_CODE) high_q <= high_q + CODE_W'(1);
        end
    end

    assign high_cnt_o = high_q;

    AST_TICK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_q <= TICK_LIM); // R9
    AST_STALL_ON_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_MEASURE && !rise_i && tick_q == TICK_LIM) |=> (state_q == ST_STALLED)); // R9
    AST_NO_BOUNDARY_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_MEASURE) |-> !boundary_o); // R8
endmodule

// File: rtl/duty_meas_predistort.sv
module duty_meas_predistort #(
    parameter int CODE_W = 6,
    parameter int PD_W   = 4
) (
    input  logic [CODE_W-1:0] raw_i,
    input  logic [PD_W-1:0]   pd_i,
    output logic [CODE_W-1:0] on_o,
    output logic [CODE_W-1:0] off_o
);
    localparam int SUM_W  = CODE_W + 2;
    localparam int PERIOD = 1 << CODE_W;
    localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};

    logic signed [SUM_W-1:0] sum_s;
    logic signed [SUM_W-1:0] pd_s;

    always_comb begin
        pd_s  = $signed({{(SUM_W-PD_W){pd_i[PD_W-1]}}, pd_i});
        sum_s = $signed({2'b00, raw_i}) + pd_s;
        if (sum_s < 0) begin
            on_o = '0;
        end else if (sum_s > $signed({2'b00, MAX_CODE})) begin
            on_o = MAX_CODE;
        end else begin
            on_o = sum_s[CODE_W-1:0];
        end
        if (on_o == '0) off_o = MAX_CODE;
        else            off_o = CODE_W'(PERIOD - int'(on_o));
    end
endmodule

// File: rtl/duty_meas_predist.sv
module duty_meas_predist #(
    parameter int CODE_W        = 6,
    parameter int PD_W          = 4,
    parameter int TIMEOUT_TICKS = 128
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sw_node_i,
    input  logic [PD_W-1:0]   predist_i,
    output logic [CODE_W-1:0] on_code_o,
    output logic [CODE_W-1:0] off_code_o,
    output logic              code_valid_o,
    output logic              timeout_o
);
    logic              level;
    logic              rise;
    logic              boundary;
    logic              stalled;
    logic [CODE_W-1:0] high_cnt;
    logic [CODE_W-1:0] adj_on;
    logic [CODE_W-1:0] adj_off;

    duty_meas_sync #(.STAGES(2)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (sw_node_i),
        .level_o (level),
        .rise_o  (rise)
    );

    duty_meas_period_fsm #(
        .CODE_W        (CODE_W),
        .TIMEOUT_TICKS (TIMEOUT_TICKS)
    ) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .level_i    (level),
        .rise_i     (rise),
        .boundary_o (boundary),
        .high_cnt_o (high_cnt),
        .stalled_o  (stalled)
    );

    duty_meas_predistort #(
        .CODE_W (CODE_W),
        .PD_W   (PD_W)
    ) u_pd (
        .raw_i (high_cnt),
        .pd_i  (predist_i),
        .on_o  (adj_on),
        .off_o (adj_off)
    );

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            on_code_o    <= '0;
            off_code_o   <= '0;
            code_valid_o <= 1'b0;
        end else begin
            code_valid_o <= boundary;
            if (boundary) begin
                on_code_o  <= adj_on;
                off_code_o <= adj_off;
            end
        end
    end

    assign timeout_o = stalled;

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        code_valid_o |=> !code_valid_o); // R6
    AST_ON_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !code_valid_o |=> (code_valid_o || $stable(on_code_o))); // R6
    AST_OFF_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !code_valid_o |=> (code_valid_o || $stable(off_code_o))); // R6
    AST_PERIOD_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (code_valid_o && on_code_o != '0) |->
            ({1'b0, on_code_o} + {1'b0, off_code_o} == (CODE_W+1)'(1 << CODE_W))); // R3
    AST_NO_VALID_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_o |-> !code_valid_o); // R9
endmodule

// File: tb/duty_meas_predist_bench.sv
module duty_meas_predist_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;
    // high ticks, predistortion, expected ON, expected OFF
    localparam int VEC_H  [NVEC] = '{13, 32, 13, 50, 62,  2, 63,  1, 60};
    localparam int VEC_PD [NVEC] = '{ 0,  0,  2, -3,  7, -8,  0, -1,  3};
    localparam int VEC_ON [NVEC] = '{13, 32, 15, 47, 63,  0, 63,  0, 63};
    localparam int VEC_OFF[NVEC] = '{51, 32, 49, 17,  1, 63,  1, 63,  1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw = 1'b0;
    logic [3:0] pd = 4'd0;
    logic [5:0] on_code, off_code;
    logic       valid, timeout;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    int cur_h = 13;
    bit run = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    duty_meas_predist u_duty_meas_predist (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .sw_node_i    (sw),
        .predist_i    (pd),
        .on_code_o    (on_code),
        .off_code_o   (off_code),
        .code_valid_o (valid),
        .timeout_o    (timeout)
    );

    always @(negedge clk) if (valid) vcount++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_valid(input string req);
        bit seen = 1'b0;
        for (int k = 0; k < 400 && !seen; k++) begin
            @(negedge clk);
            if (valid) seen = 1'b1;
        end
        if (!seen) chk(1'b0, req, 0, 1);
    endtask

    // periodic switching-node driver
    initial begin
        forever begin
            if (run) begin
                int h;
                h = cur_h;
                sw = 1'b1;
                repeat (h) @(negedge clk);
                sw = 1'b0;
                repeat (64 - h) @(negedge clk);
            end else begin
                @(negedge clk);
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int vc;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(on_code == 6'd0, "R1 on", int'(on_code), 0);
        chk(off_code == 6'd0, "R1 off", int'(off_code), 0);
        chk(!valid && !timeout, "R1 flags", int'({valid, timeout}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R8 / R7 / R2 / R3: manual first period, then measured period
        sw = 1'b1;
        repeat (20) @(negedge clk);
        sw = 1'b0;
        repeat (44) @(negedge clk);
        chk(vcount == 0, "R8 first edge publishes nothing", vcount, 0);
        sw = 1'b1;
        @(negedge clk);
        chk(!valid, "R7 not yet at E", int'(valid), 0);
        @(negedge clk);
        chk(!valid, "R7 not yet at E+1", int'(valid), 0);
        @(negedge clk);
        chk(valid, "R7 strobe at E+2", int'(valid), 1);
        chk(on_code == 6'd20, "R2 on 20", int'(on_code), 20);
        chk(off_code == 6'd44, "R3 off 44", int'(off_code), 44);
        @(negedge clk);
        chk(!valid, "R6 strobe one cycle", int'(valid), 0);
        repeat (8) @(negedge clk);
        sw = 1'b0;
        repeat (8) @(negedge clk);

        // table of duty / predistortion vectors (R2 R3 R4 R5 R6)
        run = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            cur_h = VEC_H[i];
            pd = 4'(VEC_PD[i]);
            wait_valid("R6 strobe");
            wait_valid("R6 strobe");
            wait_valid("R6 strobe");
            chk(int'(on_code) == VEC_ON[i], "R2 R4 R5 on code", int'(on_code), VEC_ON[i]);
            chk(int'(off_code) == VEC_OFF[i], "R3 off code", int'(off_code), VEC_OFF[i]);
            repeat (10) @(negedge clk);
            chk(int'(on_code) == VEC_ON[i] && !valid, "R6 on held", int'(on_code), VEC_ON[i]);
            chk(int'(off_code) == VEC_OFF[i], "R6 off held", int'(off_code), VEC_OFF[i]);
        end

        // R9: timeout with a quiet node
        run = 1'b0;
        repeat (200) @(negedge clk);
        vc = vcount;
        repeat (100) @(negedge clk);
        chk(timeout, "R9 timeout raised", int'(timeout), 1);
        chk(vcount == vc, "R9 no strobe while stalled", vcount - vc, 0);
        chk(int'(on_code) == VEC_ON[NVEC-1], "R9 on held", int'(on_code), VEC_ON[NVEC-1]);
        chk(int'(off_code) == VEC_OFF[NVEC-1], "R9 off held", int'(off_code), VEC_OFF[NVEC-1]);

        // recovery: first edge clears timeout but publishes nothing
        cur_h = 40;
        pd = 4'd0;
        run = 1'b1;
        repeat (5) @(negedge clk);
        chk(!timeout, "R9 timeout cleared", int'(timeout), 0);
        chk(vcount == vc, "R8 first edge after stall", vcount - vc, 0);
        wait_valid("R9 strobe after recovery");
        chk(on_code == 6'd40, "R2 on after recovery", int'(on_code), 40);
        chk(off_code == 6'd24, "R3 off after recovery", int'(off_code), 24);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule